// File: doc/BRIEF.md
# Receive Word Label and Decoder Filter

This block sits between the bit decoder of a serial avionics word receiver and that receiver's word FIFO. For every 32-bit word the decoder hands over, the filter decides whether the word is stored. It makes that decision by applying up to two independent checks, and each check has its own enable. The first check is label recognition, which looks for the word's 8-bit label in a programmable table of sixteen labels. The second check is a decoder match, which compares two fixed word bits against two configured reference bits.

The label table is maintained through a small side port, and a mode input selects between two uses of that port. In load mode, each write strobe places one label at an explicit index. In read mode, each read strobe returns the next stored label, walking the table from index 0 upward. The filter's output is a single accept strobe that the FIFO write logic uses directly.

Word bits are numbered 1 to 32 with bit 1 at `word[0]`. The label occupies bits 1 to 8 (`word[7:0]`), bit 9 is `word[8]` and bit 10 is `word[9]`.

Top module: `rx_label_filter`

## Requirements
- R1: While `rst_n` is low and after its release, `accept` and `tbl_rvalid` are 0, every table entry reads back as 8'h00, and the read pointer stands at index 0.
- R2: `accept` is high for exactly the one clock that follows a clock in which `word_vld` was high and every enabled check passed; without `word_vld` it stays low.
- R3: With `lbl_en` = 0 the label does not influence acceptance: a word with any value in `word[7:0]` passes the label check.
- R4: With `lbl_en` = 1 a word passes the label check only if `word[7:0]` equals at least one of the sixteen table entries.
- R5: With `dec_en` = 0, bits `word[9:8]` and `dec_ref` do not influence acceptance.
- R6: With `dec_en` = 1 a word is rejected unless `word[8]` equals `dec_ref[0]` and `word[9]` equals `dec_ref[1]`.
- R7: When both checks are enabled, a word is accepted only when both of them pass; bits `word[31:10]` never influence acceptance.
- R8: With `tbl_mode` = 0 (load), a `tbl_wr` pulse stores `tbl_wdata` into the entry `tbl_widx`. With `tbl_mode` = 1, `tbl_wr` leaves the table unchanged.
- R9: With `tbl_mode` = 1 (read), each `tbl_rd` pulse returns the entry at the read pointer on `tbl_rdata`, with `tbl_rvalid` high in the following clock, and then advances the pointer. The pointer wraps from 15 back to 0, and any clock spent in load mode returns it to 0.
- R10: With `tbl_mode` = 0, `tbl_rd` has no effect: `tbl_rvalid` stays low and the read pointer stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lbl_en | input | 1 | Label recognition enable |
| dec_en | input | 1 | Bit 9/10 decoder check enable |
| dec_ref | input | 2 | Reference bits: [0] for word bit 9, [1] for word bit 10 |
| tbl_mode | input | 1 | Table port mode: 0 load, 1 read back |
| tbl_wr | input | 1 | Table write strobe (load mode) |
| tbl_widx | input | 4 | Table write index |
| tbl_wdata | input | 8 | Label to store |
| tbl_rd | input | 1 | Table read strobe (read mode) |
| tbl_rdata | output | 8 | Label read back |
| tbl_rvalid | output | 1 | `tbl_rdata` valid this clock |
| word_vld | input | 1 | Received word strobe |
| word | input | 32 | Received word, bit 1 at `word[0]` |
| accept | output | 1 | Write the word into the FIFO |

## Verification
A corrupted table entry, or a comparator that is wired to the wrong entry, shows up as a wrong `accept` on the first word whose label targets that entry, which is one clock after that word's strobe. The same fault also shows up on `tbl_rdata` during the next read-back sweep. A read pointer that is off or misses its wrap returns labels out of index order on the very next read. A fault in the decoder compare inverts `accept` only for words whose bits 9 and 10 disagree with the references. For this reason the stimulus mixes in words whose labels come from the table and words whose bits 9 and 10 vary, under every combination of the two enables.

// File: rtl/lf_pkg.sv
// Package: shared types for the receive label/decoder filter.
// Assumes: table port mode encoding is fixed by the block's port contract.
package lf_pkg;
    typedef enum logic {
        TBL_LOAD = 1'b0,
        TBL_READ = 1'b1
    } tbl_mode_e;

    // Width of the decoder reference: word bits 9 and 10.
    localparam int unsigned DEC_W = 2;
endpackage

// File: rtl/lf_label_table.sv
// Module: lf_label_table
// Holds NUM_LABELS labels. In load mode, writes land at an explicit index.
// In read mode, reads return entries in index order through a wrapping pointer.
// Assumes: tbl_widx is below NUM_LABELS; mode is stable around strobes.
module lf_label_table #(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned LABEL_W    = 8,
    localparam int unsigned IDX_W     = $clog2(NUM_LABELS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  lf_pkg::tbl_mode_e             mode,
    input  logic                          wr,
    input  logic [IDX_W-1:0]              widx,
    input  logic [LABEL_W-1:0]            wdata,
    input  logic                          rd,
    output logic [LABEL_W-1:0]            rdata,
    output logic                          rvalid,
    output logic [NUM_LABELS*LABEL_W-1:0] tbl_flat
);
    import lf_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LABELS - 1);

    logic [LABEL_W-1:0] ents [NUM_LABELS];
    logic [IDX_W-1:0]   rptr;

    // One storage register per entry, written only in load mode.
    for (genvar i = 0; i < NUM_LABELS; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ents[i] <= '0;
            else if (mode == TBL_LOAD && wr && widx == IDX_W'(i))
                ents[i] <= wdata;
        end
        assign tbl_flat[i*LABEL_W +: LABEL_W] = ents[i];
    end

    // Read pointer: cleared in load mode, advanced and wrapped per read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rptr <= '0;
        else if (mode == TBL_LOAD)
            rptr <= '0;
        else if (rd)
            rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
    end

    // Read data register and its one-clock valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd && (mode == TBL_READ);
            if (rd && mode == TBL_READ)
                rdata <= ents[rptr];
        end
    end

    // R9/R10: valid only follows a read strobe made in read mode.
    assert_rvalid_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($past(rd) && $past(mode) == TBL_READ));

    // R10: a clock spent in load mode leaves the pointer at zero.
    assert_ptr_home_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == TBL_LOAD) |-> (rptr == '0));
endmodule

// File: rtl/lf_label_match.sv
// Module: lf_label_match
// Compares one label against every table entry in parallel and reports any hit.
// Assumes: tbl_flat packs entry i at bits [i*LABEL_W +: LABEL_W].
module lf_label_match #(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned LABEL_W    = 8
) (
    input  logic [NUM_LABELS*LABEL_W-1:0] tbl_flat,
    input  logic [LABEL_W-1:0]            label,
    output logic                          hit
);
    logic [NUM_LABELS-1:0] hits;

    for (genvar i = 0; i < NUM_LABELS; i++) begin : g_cmp
        assign hits[i] = (tbl_flat[i*LABEL_W +: LABEL_W] == label);
    end

    // Reduce the per-entry compares into one hit flag.
    always_comb hit = |hits;
endmodule

// File: rtl/lf_dec_check.sv
// Module: lf_dec_check
// Checks the two decoder bits against the configured references when enabled.
// Assumes: bits[0] carries word bit 9 and bits[1] carries word bit 10.
module lf_dec_check #(
    parameter int unsigned DEC_W = lf_pkg::DEC_W
) (
    input  logic             en,
    input  logic [DEC_W-1:0] ref_bits,
    input  logic [DEC_W-1:0] bits,
    output logic             pass
);
    // Pass when disabled, or when every bit equals its reference.
    always_comb pass = !en || (bits == ref_bits);
endmodule

// File: rtl/rx_label_filter.sv
// Module: rx_label_filter (top)
// Decides per received word whether it is written into the receiver FIFO.
// The optional checks are label recognition and the bit 9/10 decoder match.
// The accept strobe is registered: it appears one clock after word_vld.
// Assumes: a table write and a word are not presented in the same clock.
module rx_label_filter #(
    parameter int unsigned NUM_LABELS = 16,
    parameter int unsigned LABEL_W    = 8,
    parameter int unsigned WORD_W     = 32,
    localparam int unsigned IDX_W     = $clog2(NUM_LABELS),
    localparam int unsigned DEC_W     = lf_pkg::DEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lbl_en,
    input  logic               dec_en,
    input  logic [DEC_W-1:0]   dec_ref,
    input  logic               tbl_mode,
    input  logic               tbl_wr,
    input  logic [IDX_W-1:0]   tbl_widx,
    input  logic [LABEL_W-1:0] tbl_wdata,
    input  logic               tbl_rd,
    output logic [LABEL_W-1:0] tbl_rdata,
    output logic               tbl_rvalid,
    input  logic               word_vld,
    input  logic [WORD_W-1:0]  word,
    output logic               accept
);
    import lf_pkg::*;

    localparam int unsigned DEC_LSB = LABEL_W;
    localparam int unsigned HI_LSB  = DEC_LSB + DEC_W;

    logic [NUM_LABELS*LABEL_W-1:0] tbl_flat;
    logic                          lbl_hit;
    logic                          dec_pass;
    logic                          lbl_pass;
    tbl_mode_e                     mode_q;
    logic                          unused_hi;

    assign mode_q    = tbl_mode_e'(tbl_mode);
    assign unused_hi = ^word[WORD_W-1:HI_LSB];

    lf_label_table #(
        .NUM_LABELS (NUM_LABELS),
        .LABEL_W    (LABEL_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .wr       (tbl_wr),
        .widx     (tbl_widx),
        .wdata    (tbl_wdata),
        .rd       (tbl_rd),
        .rdata    (tbl_rdata),
        .rvalid   (tbl_rvalid),
        .tbl_flat (tbl_flat)
    );

    lf_label_match #(
        .NUM_LABELS (NUM_LABELS),
        .LABEL_W    (LABEL_W)
    ) u_match (
        .tbl_flat (tbl_flat),
        .label    (word[LABEL_W-1:0]),
        .hit      (lbl_hit)
    );

    lf_dec_check #(
        .DEC_W (DEC_W)
    ) u_dec (
        .en       (dec_en),
        .ref_bits (dec_ref),
        .bits     (word[DEC_LSB +: DEC_W]),
        .pass     (dec_pass)
    );

    // Label check result: forced to pass when recognition is off.
    always_comb lbl_pass = !lbl_en || lbl_hit;

    // Register the accept decision one clock after the word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            accept <= 1'b0;
        else
            accept <= word_vld && lbl_pass && dec_pass;
    end

    // R2: no accept without a word strobe in the previous clock.
    assert_accept_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(word_vld));

    // R3/R5: with both checks off, every strobed word is accepted.
    assert_open_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(word_vld) && !$past(lbl_en) && !$past(dec_en))
        |-> accept);

    // R4: an accepted word under recognition had a table hit.
    assert_label_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(lbl_en)) |-> $past(lbl_hit));

    // R6: an accepted word under the decoder check matched both references.
    assert_dec_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(dec_en)) |-> ($past(word[DEC_LSB +: DEC_W]) == $past(dec_ref)));
endmodule

// File: tb/tb_rx_label_filter.sv
`timescale 1ns/1ps
module tb_rx_label_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lbl_en = 1'b0;
    logic        dec_en = 1'b0;
    logic [1:0]  dec_ref = 2'b00;
    logic        tbl_mode = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [3:0]  tbl_widx = 4'd0;
    logic [7:0]  tbl_wdata = 8'd0;
    logic        tbl_rd = 1'b0;
    logic [7:0]  tbl_rdata;
    logic        tbl_rvalid;
    logic        word_vld = 1'b0;
    logic [31:0] word = 32'd0;
    logic        accept;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] model [16];

    rx_label_filter dut (
        .clk(clk), .rst_n(rst_n), .lbl_en(lbl_en), .dec_en(dec_en),
        .dec_ref(dec_ref), .tbl_mode(tbl_mode), .tbl_wr(tbl_wr),
        .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata), .tbl_rd(tbl_rd),
        .tbl_rdata(tbl_rdata), .tbl_rvalid(tbl_rvalid),
        .word_vld(word_vld), .word(word), .accept(accept)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic exp_accept(input logic [31:0] w, input logic le,
                                        input logic de, input logic [1:0] r);
        logic hit = 1'b0;
        for (int i = 0; i < 16; i++) if (model[i] == w[7:0]) hit = 1'b1;
        return (!le || hit) && (!de || (w[8] == r[0] && w[9] == r[1]));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_word(input string req, input logic [31:0] w);
        logic e;
        e = exp_accept(w, lbl_en, dec_en, dec_ref);
        word_vld = 1'b1;
        word = w;
        @(negedge clk);
        word_vld = 1'b0;
        word = $urandom;
        check(req, {31'd0, accept}, {31'd0, e});
        @(negedge clk);
        check("R2 accept one clock only", {31'd0, accept}, 32'd0);
    endtask

    task automatic write_lbl(input logic [3:0] idx, input logic [7:0] v);
        tbl_wr = 1'b1; tbl_widx = idx; tbl_wdata = v;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (tbl_mode == 1'b0) model[idx] = v;
    endtask

    task automatic read_lbl(input string req, input logic [7:0] exp);
        tbl_rd = 1'b1;
        @(negedge clk);
        tbl_rd = 1'b0;
        check(req, {31'd0, tbl_rvalid}, 32'd1);
        check(req, {24'd0, tbl_rdata}, {24'd0, exp});
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 accept in reset", {31'd0, accept}, 32'd0);
        check("R1 rvalid in reset", {31'd0, tbl_rvalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 accept after reset", {31'd0, accept}, 32'd0);

        // R1: table clear, read back from index 0
        tbl_mode = 1'b1;
        for (int i = 0; i < 16; i++) read_lbl("R1 table clear", 8'h00);

        // R10: read strobe in load mode is ignored
        tbl_mode = 1'b0;
        tbl_rd = 1'b1;
        @(negedge clk);
        tbl_rd = 1'b0;
        check("R10 rvalid low in load mode", {31'd0, tbl_rvalid}, 32'd0);

        // R8: load the table
        for (int i = 0; i < 16; i++) write_lbl(4'(i), 8'h11 + 8'(i * 13));

        // R9: read in order and wrap
        tbl_mode = 1'b1;
        for (int i = 0; i < 16; i++) read_lbl("R9 index order", model[i]);
        read_lbl("R9 wrap to 0", model[0]);
        read_lbl("R9 after wrap", model[1]);

        // R8: write in read mode ignored
        write_lbl(4'd2, 8'hEE);
        read_lbl("R8 write ignored in read mode", model[2]);

        // R9/R10: load mode returns pointer to 0
        tbl_mode = 1'b0;
        tbl_rd = 1'b1;
        @(negedge clk);
        tbl_rd = 1'b0;
        tbl_mode = 1'b1;
        read_lbl("R9 pointer home after load", model[0]);
        tbl_mode = 1'b0;
        @(negedge clk);

        // Directed acceptance corners
        lbl_en = 0; dec_en = 0;
        send_word("R3 any label passes", 32'hFFFF_FFAB);
        check("R2 no accept idle", {31'd0, accept}, 32'd0);
        lbl_en = 1;
        send_word("R4 label hit", {22'h3FFFFF, 2'b10, model[15]});
        send_word("R4 label miss", {22'h0, 2'b00, 8'h00});
        lbl_en = 0; dec_en = 1; dec_ref = 2'b01;
        send_word("R6 bits match", {22'h0, 2'b01, 8'h00});
        send_word("R6 bit9 mismatch", {22'h0, 2'b00, 8'h00});
        send_word("R6 bit10 mismatch", {22'h0, 2'b11, 8'h00});
        dec_en = 0;
        send_word("R5 decoder off", {22'h155, 2'b10, 8'h5A});
        lbl_en = 1; dec_en = 1; dec_ref = 2'b10;
        send_word("R7 both pass", {22'h2AA, 2'b10, model[7]});
        send_word("R7 label fails", {22'h0, 2'b10, 8'h00});
        send_word("R7 decoder fails", {22'h0, 2'b01, model[7]});

        // Randomized sweep
        for (int n = 0; n < 400; n++) begin
            logic [31:0] w;
            lbl_en = 1'($urandom);
            dec_en = 1'($urandom);
            dec_ref = 2'($urandom);
            w = $urandom;
            if ($urandom % 2 == 0) w[7:0] = model[$urandom % 16];
            send_word("R7 random word", w);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule